// File: doc/BRIEF.md
# Read-Only NAND Flash Responder

This block answers a host that talks to a small NAND-style flash over a byte-wide bus with active-low chip enables, command and address latch strobes, and active-low read and write strobes. It holds two independent devices behind one bus. The host writes a command byte to pick a read mode, writes three address bytes to position a pointer, and then pulses the read strobe once for each byte. Each pulse returns the byte under the pointer and advances the pointer by one.

Pages are 528 bytes long: 256 bytes of lower half, 256 of upper half and 16 spare bytes. The read-mode command chooses where the column byte lands. The first mode reads the lower half, the second forces the upper half and the third forces the spare area. The second address byte selects a group of 256 pages. The third selects a page within that group. The contents are read-only and are computed at elaboration. Command sequences that cannot be obeyed are not allowed to halt anything. Instead they raise a per-device sticky error bit, and a reset command clears it.

All strobes are sampled on the system clock. An action fires on the clock edge that first sees a strobe low after it was high. Results appear on the registered outputs one cycle later.

Top module: `nand_read_resp`

## Requirements
- R1: `ceA_n` low selects device A, whatever `ceB_n` is. `ceB_n` low with `ceA_n` high selects device B. With both high, no strobe changes any pointer, mode, error bit, `dataOut` or `dataOe`.
- R2: A write-strobe fall with `cmdLatch` high latches `dataIn` as a command. 0x00 enters mode 1, 0x01 enters mode 2, 0x50 enters mode 3, and 0xFF returns to idle. Each read-mode command restarts the address byte count.
- R3: The first address byte after a read-mode command sets the pointer to that byte. In mode 2 it is ORed with 0x100, and in mode 3 it is ORed with 0x200.
- R4: The second address byte adds byte × 135168 (528 × 256) to the pointer. The third adds byte × 528. All pointer arithmetic wraps at 24 bits.
- R5: A read-strobe fall with both latches low loads `dataOut` with the byte at the pointer, one cycle after the sampling edge, and then adds one to the pointer.
- R6: A fourth address byte, an address byte while idle, or a command byte other than 0x00, 0x01, 0x50 or 0xFF sets that device's sticky error output. Command 0xFF clears it.
- R7: `dataOe` is high only in the cycle after an edge that saw a device selected, `readEn_n` low and both latches low. Otherwise it is low.
- R8: A device's ready output goes high once it has been selected with both read and write strobes high. After that it never falls, because the device is never busy.
- R9: The byte at pointer p is read from index i = p mod DEPTH. With PRELOAD = 0 every byte is 0xFF. With PRELOAD = 1 it is (i[7:0] + 37·i[15:8] + 11·i[23:16]) mod 256.
- R10: The two devices keep separate modes, pointers and error bits. Traffic to one device never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ceA_n | input | 1 | Device A enable, active low, has priority |
| ceB_n | input | 1 | Device B enable, active low |
| cmdLatch | input | 1 | Command latch strobe |
| addrLatch | input | 1 | Address latch strobe |
| readEn_n | input | 1 | Read strobe, active low |
| writeEn_n | input | 1 | Write strobe, active low |
| dataIn | input | 8 | Command or address byte from the host |
| dataOut | output | 8 | Last byte read |
| dataOe | output | 1 | High while the block drives the data bus |
| readyA | output | 1 | Device A ready |
| readyB | output | 1 | Device B ready |
| errA | output | 1 | Device A sticky error |
| errB | output | 1 | Device B sticky error |

## Verification
A corrupted pointer or mode stays hidden until the next read strobe. It then shows as a wrong byte on `dataOut` one cycle after the sampling edge. The pattern preload makes every pointer bit up to the window width change the byte returned. For this reason the bench reads right after each address setup and reads again after traffic to the other device or to no device. A wrong address byte count or error state shows on the error outputs in the cycle after the offending strobe. A wrong enable decode shows either as a read that skips bytes or as `dataOe` rising when no device is selected.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_RD3  = 2'd3
  } nrrState_t;

  // strobes from control to datapath, at most one action set per cycle
  typedef struct packed {
    logic       ldCol;
    logic       addBlk;
    logic       addPg;
    logic       incr;
    logic [1:0] colHi;
  } nrrCtl_t;

  localparam int unsigned PTR_W = 24;

  // content of the read-only store at a given index
  function automatic logic [7:0] fillByte(input logic pattern, input logic [PTR_W-1:0] idx);
    logic [7:0] acc;
    if (!pattern) begin
      acc = 8'hFF;
    end else begin
      acc = idx[7:0] + (idx[15:8] * 8'd37) + (idx[23:16] * 8'd11);
    end
    return acc;
  endfunction

endpackage

// File: rtl/nrr_ctrl.sv
module nrr_ctrl
  import nrr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdEv,
  input  logic       addrEv,
  input  logic       rdEv,
  input  logic [7:0] busByte,
  output nrrCtl_t    ctl,
  output logic       errFlag
);

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_LOW   = 8'h00;
  localparam logic [7:0] CMD_HIGH  = 8'h01;
  localparam logic [7:0] CMD_SPARE = 8'h50;

  nrrState_t  state;
  logic [1:0] addrCnt;

  always_comb begin
    ctl = '0;
    ctl.incr = rdEv;
    if (addrEv && state != ST_IDLE) begin
      unique case (addrCnt)
        2'd0: begin
          ctl.ldCol = 1'b1;
          ctl.colHi = (state == ST_RD2) ? 2'b01 :
                      (state == ST_RD3) ? 2'b10 : 2'b00;
        end
        2'd1:    ctl.addBlk = 1'b1;
        2'd2:    ctl.addPg  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addrCnt <= 2'd0;
      errFlag <= 1'b0;
    end else if (cmdEv) begin
      unique case (busByte)
        CMD_RESET: begin
          state   <= ST_IDLE;
          addrCnt <= 2'd0;
          errFlag <= 1'b0;
        end
        CMD_LOW:   begin state <= ST_RD1; addrCnt <= 2'd0; end
        CMD_HIGH:  begin state <= ST_RD2; addrCnt <= 2'd0; end
        CMD_SPARE: begin state <= ST_RD3; addrCnt <= 2'd0; end
        default:   errFlag <= 1'b1;
      endcase
    end else if (addrEv) begin
      if (state == ST_IDLE || addrCnt == 2'd3) begin
        errFlag <= 1'b1;
      end else begin
        addrCnt <= addrCnt + 2'd1;
      end
    end
  end

  // R2
  spare_cmd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdEv && busByte == CMD_SPARE) |=> (state == ST_RD3 && addrCnt == 2'd0));

  // R6
  idle_addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addrEv && !cmdEv && state == ST_IDLE) |=> errFlag);

  // R6
  reset_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdEv && busByte == CMD_RESET) |=> (!errFlag && state == ST_IDLE));

endmodule

// File: rtl/nrr_dpath.sv
module nrr_dpath
  import nrr_pkg::*;
#(
  parameter int unsigned DEPTH   = 1024,
  parameter bit          PRELOAD = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  nrrCtl_t    ctl,
  input  logic [7:0] busByte,
  output logic [7:0] rdByte
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] blkStep;
  logic [PTR_W-1:0] pgStep;
  logic [PTR_W-1:0] storeIdx;

  // byte * 528 * 256 = byte<<17 + byte<<12 ; byte * 528 = byte<<9 + byte<<4
  assign blkStep = (PTR_W'(busByte) << 17) + (PTR_W'(busByte) << 12);
  assign pgStep  = (PTR_W'(busByte) << 9)  + (PTR_W'(busByte) << 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ctl.ldCol) begin
      ptr <= {{(PTR_W-10){1'b0}}, ctl.colHi, busByte};
    end else if (ctl.addBlk) begin
      ptr <= ptr + blkStep;
    end else if (ctl.addPg) begin
      ptr <= ptr + pgStep;
    end else if (ctl.incr) begin
      ptr <= ptr + 1'b1;
    end
  end

  generate
    if (IDX_W >= PTR_W) begin : g_fullIdx
      assign storeIdx = ptr;
    end else begin : g_winIdx
      assign storeIdx = PTR_W'(ptr[IDX_W-1:0]);
    end
  endgenerate

  assign rdByte = fillByte(PRELOAD, storeIdx);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.incr && !ctl.ldCol && !ctl.addBlk && !ctl.addPg) |=> (ptr == $past(ptr) + 1'b1));

  // R3
  col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ldCol |=> (ptr[PTR_W-1:10] == '0 && ptr[7:0] == $past(busByte)));

  // R4
  page_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.addPg |=> (ptr - $past(ptr) == PTR_W'($past(busByte)) * PTR_W'(528)));

endmodule

// File: rtl/nand_read_resp.sv
module nand_read_resp
  import nrr_pkg::*;
#(
  parameter int unsigned DEPTH   = 1024,
  parameter bit          PRELOAD = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ceA_n,
  input  logic       ceB_n,
  input  logic       cmdLatch,
  input  logic       addrLatch,
  input  logic       readEn_n,
  input  logic       writeEn_n,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       readyA,
  output logic       readyB,
  output logic       errA,
  output logic       errB
);

  localparam int unsigned NDEV = 2;

  logic            wePrev, rePrev;
  logic            weFall, reFall;
  logic [NDEV-1:0] sel, cmdEv, addrEv, rdEv, errVec, rdyVec;
  logic [7:0]      rdByte [NDEV];

  assign weFall = wePrev & ~writeEn_n;
  assign reFall = rePrev & ~readEn_n;
  assign sel[0] = ~ceA_n;
  assign sel[1] = ceA_n & ~ceB_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wePrev <= 1'b1;
      rePrev <= 1'b1;
    end else begin
      wePrev <= writeEn_n;
      rePrev <= readEn_n;
    end
  end

  generate
    for (genvar g = 0; g < NDEV; g++) begin : g_dev
      nrrCtl_t ctl;

      assign cmdEv[g]  = sel[g] & weFall & cmdLatch;
      assign addrEv[g] = sel[g] & weFall & ~cmdLatch & addrLatch;
      assign rdEv[g]   = sel[g] & reFall & ~cmdLatch & ~addrLatch;

      nrr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmdEv   (cmdEv[g]),
        .addrEv  (addrEv[g]),
        .rdEv    (rdEv[g]),
        .busByte (dataIn),
        .ctl     (ctl),
        .errFlag (errVec[g])
      );

      nrr_dpath #(
        .DEPTH   (DEPTH),
        .PRELOAD (PRELOAD)
      ) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .busByte (dataIn),
        .rdByte  (rdByte[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdyVec[g] <= 1'b0;
        end else if (sel[g] && readEn_n && writeEn_n) begin
          rdyVec[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut <= 8'h00;
      dataOe  <= 1'b0;
    end else begin
      dataOe <= (|sel) & ~readEn_n & ~cmdLatch & ~addrLatch;
      if (rdEv[0]) begin
        dataOut <= rdByte[0];
      end else if (rdEv[1]) begin
        dataOut <= rdByte[1];
      end
    end
  end

  assign readyA = rdyVec[0];
  assign readyB = rdyVec[1];
  assign errA   = errVec[0];
  assign errB   = errVec[1];

  // R7
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> ($past(!readEn_n) && $past(!ceA_n || !ceB_n)));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(readyA) && !$fell(readyB));

  // R1
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ceA_n && ceB_n) |=> ($stable(dataOut) && !dataOe));

  // R1
  single_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdEv | cmdEv | addrEv));

endmodule

// File: tb/nand_read_resp_tb.sv
module nand_read_resp_tb;

  localparam int unsigned TB_DEPTH = 1 << 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ceA_n = 1'b1, ceB_n = 1'b1;
  logic       cmdLatch = 1'b0, addrLatch = 1'b0;
  logic       readEn_n = 1'b1, writeEn_n = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut, dataOutFf;
  logic       dataOe, readyA, readyB, errA, errB;
  logic       dataOeFf, readyAFf, readyBFf, errAFf, errBFf;

  int nChk = 0;
  int nFail = 0;
  int expPtr [2];

  always #2 clk = ~clk;

  nand_read_resp #(.DEPTH(TB_DEPTH), .PRELOAD(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ceA_n(ceA_n), .ceB_n(ceB_n),
    .cmdLatch(cmdLatch), .addrLatch(addrLatch), .readEn_n(readEn_n),
    .writeEn_n(writeEn_n), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .readyA(readyA), .readyB(readyB), .errA(errA), .errB(errB)
  );

  nand_read_resp u_dutFf (
    .clk(clk), .rst_n(rst_n), .ceA_n(ceA_n), .ceB_n(ceB_n),
    .cmdLatch(cmdLatch), .addrLatch(addrLatch), .readEn_n(readEn_n),
    .writeEn_n(writeEn_n), .dataIn(dataIn), .dataOut(dataOutFf),
    .dataOe(dataOeFf), .readyA(readyAFf), .readyB(readyBFf), .errA(errAFf), .errB(errBFf)
  );

  function automatic int patByte(input int p);
    int i;
    i = p % TB_DEPTH;
    return ((i & 255) + 37 * ((i >> 8) & 255) + 11 * ((i >> 16) & 255)) & 255;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // dev: 0 = A, 1 = B, 2 = none, 3 = both enables low
  task automatic selDev(input int dev);
    ceA_n = !(dev == 0 || dev == 3);
    ceB_n = !(dev == 1 || dev == 3);
  endtask

  task automatic wrCycle(input int dev, input bit isCmd, input logic [7:0] v);
    @(negedge clk);
    selDev(dev); cmdLatch = isCmd; addrLatch = !isCmd; dataIn = v; writeEn_n = 1'b0;
    @(negedge clk);
    writeEn_n = 1'b1;
    @(negedge clk);
    cmdLatch = 1'b0; addrLatch = 1'b0; selDev(2);
  endtask

  task automatic rdCycle(input int dev, output int v, output int oe, output int vFf);
    @(negedge clk);
    selDev(dev); readEn_n = 1'b0;
    @(negedge clk);
    v = dataOut; oe = dataOe; vFf = dataOutFf;
    readEn_n = 1'b1;
    @(negedge clk);
    selDev(2);
  endtask

  task automatic setAddr(input int dev, input logic [7:0] cmd, input int c, input int b, input int p);
    int off;
    off = (cmd == 8'h01) ? 256 : (cmd == 8'h50) ? 512 : 0;
    wrCycle(dev, 1'b1, cmd);
    wrCycle(dev, 1'b0, 8'(c));
    wrCycle(dev, 1'b0, 8'(b));
    wrCycle(dev, 1'b0, 8'(p));
    expPtr[dev == 1 ? 1 : 0] = ((c | off) + b * 135168 + p * 528) & 24'hFFFFFF;
  endtask

  task automatic readExp(input int dev, input string req);
    int v, oe, vFf, d;
    d = (dev == 1) ? 1 : 0;
    rdCycle(dev, v, oe, vFf);
    check({req, " data"}, v, patByte(expPtr[d]));
    check("R7 oe during read", oe, 1);
    expPtr[d] = (expPtr[d] + 1) & 24'hFFFFFF;
  endtask

  task automatic t_reset();
    check("R7 oe at reset", dataOe, 0);
    check("R8 readyA at reset", readyA, 0);
    check("R8 readyB at reset", readyB, 0);
    check("R6 errA at reset", errA, 0);
    check("R6 errB at reset", errB, 0);
  endtask

  task automatic t_ready();
    @(negedge clk); selDev(0);
    @(negedge clk);
    check("R8 readyA set", readyA, 1);
    check("R8 readyB untouched", readyB, 0);
    selDev(1);
    @(negedge clk);
    check("R8 readyB set", readyB, 1);
    check("R8 readyA holds", readyA, 1);
    selDev(2);
  endtask

  task automatic t_mode1();
    setAddr(0, 8'h00, 8'h05, 0, 2);
    check("R2 no error on valid sequence", errA, 0);
    for (int k = 0; k < 3; k++) readExp(0, "R3 R4 R5 mode1");
  endtask

  task automatic t_mode2();
    setAddr(0, 8'h01, 8'h10, 0, 1);
    readExp(0, "R3 mode2 upper half");
    readExp(0, "R5 mode2 next");
  endtask

  task automatic t_mode3();
    setAddr(0, 8'h50, 8'h03, 0, 0);
    readExp(0, "R3 mode3 spare");
  endtask

  task automatic t_block();
    setAddr(0, 8'h00, 8'h04, 2, 3);
    readExp(0, "R4 block and page");
    readExp(0, "R5 block next");
  endtask

  task automatic t_errors();
    wrCycle(1, 1'b1, 8'hFF);
    wrCycle(1, 1'b0, 8'h12);
    check("R6 address while idle", errB, 1);
    check("R10 other device error", errA, 0);
    wrCycle(1, 1'b1, 8'hFF);
    check("R6 reset clears", errB, 0);
    setAddr(1, 8'h00, 1, 1, 1);
    check("R6 three cycles legal", errB, 0);
    wrCycle(1, 1'b0, 8'h07);
    check("R6 fourth cycle", errB, 1);
    wrCycle(1, 1'b1, 8'hFF);
    check("R6 reset clears again", errB, 0);
    wrCycle(1, 1'b1, 8'h33);
    check("R6 unknown command", errB, 1);
    wrCycle(1, 1'b1, 8'hFF);
    check("R6 reset after unknown", errB, 0);
  endtask

  task automatic t_select();
    int v, oe, vFf, held;
    setAddr(0, 8'h00, 8'h20, 0, 5);
    setAddr(1, 8'h00, 8'h40, 1, 0);
    readExp(3, "R1 both enables pick A");
    rdCycle(3, v, oe, vFf);
    held = v;
    check("R1 both enables A data", v, patByte(expPtr[0]));
    expPtr[0] = expPtr[0] + 1;
    rdCycle(2, v, oe, vFf);
    check("R1 no select oe", oe, 0);
    check("R1 no select data held", v, held);
    wrCycle(2, 1'b1, 8'h33);
    check("R1 no select no error", errA | errB, 0);
    readExp(0, "R1 A pointer not advanced");
    readExp(1, "R1 B untouched");
  endtask

  task automatic t_oeMask();
    @(negedge clk);
    selDev(0); addrLatch = 1'b1; readEn_n = 1'b0;
    @(negedge clk);
    check("R7 oe masked by latch", dataOe, 0);
    readEn_n = 1'b1; addrLatch = 1'b0;
    @(negedge clk);
    selDev(2);
    readExp(0, "R7 masked strobe did not read");
  endtask

  task automatic t_preloadFf();
    int v, oe, vFf;
    rdCycle(0, v, oe, vFf);
    check("R9 blank store", vFf, 8'hFF);
    expPtr[0] = expPtr[0] + 1;
  endtask

  task automatic t_indep();
    setAddr(0, 8'h01, 8'h77, 3, 9);
    setAddr(1, 8'h50, 8'h0A, 4, 2);
    readExp(1, "R10 B own pointer");
    readExp(0, "R10 A own pointer");
    readExp(1, "R10 B continues");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ready();
    t_mode1();
    t_mode2();
    t_mode3();
    t_block();
    t_errors();
    t_select();
    t_oeMask();
    t_preloadFf();
    t_indep();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule